// File: doc/BRIEF.md
# Virtual Interrupt Priority Selector

This block picks the single most urgent pending virtual interrupt for one virtual processor. It looks at a bank of list-register entries, each with a two-bit state, an eight-bit priority and a group bit. It also looks at one extra pending message-signalled candidate that is kept apart from the list registers. The result is a small index with three meanings: the number of the winning list-register entry, a reserved code for the message-signalled candidate, or a "nothing pending" value.

Interrupt-signalling logic, acknowledge logic and pending-query logic downstream all consume the same registered index. A separate flag tells those consumers whether anything was found, so they do not have to decode the sentinel themselves. A one-cycle strobe marks the cycles in which the registered selection has just changed. Lower priority values are more urgent. A priority of all ones is the idle marker, and it can never be selected.

Top module: `vprio_sel`

## Requirements
- R1: While reset is held, sel_idx_o is 31 (all ones), sel_none_o is 1 and sel_vld_o is 0.
- R2: A list-register entry is eligible only when all three of these hold: its state equals 2'b01 (pending only; 2'b00 idle, 2'b10 active and 2'b11 active-and-pending are never eligible), the enable of its group is set (group bit 0 uses ven0_i, group bit 1 uses ven1_i), and its priority is not 8'hFF. Among eligible entries, the smallest priority value wins and its index is reported.
- R3: When several eligible entries share the smallest priority, the entry with the lowest index wins.
- R4: When neither an entry nor the candidate is selected, sel_idx_o is 31 (the value -1 in five-bit two's complement) and sel_none_o is 1. Otherwise sel_none_o is 0.
- R5: The message-signalled candidate is reported as index 16. It wins only when its priority is strictly smaller than that of the best eligible entry. With no eligible entry, it wins when its priority is below 8'hFF. On equal priority the entry wins.
- R6: When secure_i is 1, the candidate is never selected, whatever its priority.
- R7: A candidate with cand_grp_i = 0 may win only if ven0_i is 1. One with cand_grp_i = 1 may win only if ven1_i is 1.
- R8: The outputs in each cycle reflect the inputs sampled at the preceding rising clock edge, one register stage.
- R9: sel_vld_o is 1 for exactly the cycles whose registered index differs from the one registered before it. It is also 1 for the first registered result after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_state_i | input | NUM_LR x 2 | Per-entry state: bit 0 pending, bit 1 active |
| lr_prio_i | input | NUM_LR x PRIO_W | Per-entry priority, lower is more urgent |
| lr_grp_i | input | NUM_LR | Per-entry group bit |
| cand_prio_i | input | PRIO_W | Priority of the message-signalled candidate; all ones means none |
| cand_grp_i | input | 1 | Group of the candidate |
| secure_i | input | 1 | Processor is in secure state; blocks the candidate |
| ven0_i | input | 1 | Virtual group-0 enable |
| ven1_i | input | 1 | Virtual group-1 enable |
| sel_idx_o | output | 5 | Selected index: entry 0..15, 16 for the candidate, 31 for none |
| sel_none_o | output | 1 | Nothing selected |
| sel_vld_o | output | 1 | Registered index changed (or first result after reset) |

## Verification
The assertions check the following on every cycle:
- the index stays inside its three legal ranges and agrees with the none flag;
- a reported entry was pending-only one cycle earlier;
- the candidate code never appears after a secure cycle, after a cycle with its group disabled, or with an idle priority;
- every change of index comes with the strobe.

Only the bench scenarios show which entry wins: minimum-priority choice, lowest-index tie breaking, and the strict-less-than boundary between the candidate and an entry of equal priority. They also show that the strobe stays low while inputs are held. These scenarios compare against a behavioural model each clock.

// File: rtl/vprio_pkg.sv
package vprio_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // List-register entry state encoding: bit 0 pending, bit 1 active
    typedef enum logic [1:0] {
        LR_IDLE = 2'b00,
        LR_PEND = 2'b01,
        LR_ACT  = 2'b10,
        LR_PACT = 2'b11
    } lr_state_e;

    localparam logic GRP0 = 1'b0;
    localparam logic GRP1 = 1'b1;
endpackage

// File: rtl/vprio_lr_scan.sv
// Balanced compare tree over the list-register entries.
// Leaves are masked to all ones when not eligible; each node keeps the
// left (lower index) child unless the right one is strictly smaller.
module vprio_lr_scan #(
    parameter int NUM_LR   = 16,
    parameter int PRIO_W   = 8,
    parameter int LR_IDX_W = 4
) (
    input  logic [NUM_LR-1:0][1:0]        lr_state_i,
    input  logic [NUM_LR-1:0][PRIO_W-1:0] lr_prio_i,
    input  logic [NUM_LR-1:0]             lr_grp_i,
    input  logic                          ven0_i,
    input  logic                          ven1_i,
    output logic [PRIO_W-1:0]             best_prio_o,
    output logic [LR_IDX_W-1:0]           best_idx_o,
    output logic                          best_hit_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import vprio_pkg::*;

    localparam int LVLS   = (NUM_LR > 1) ? $clog2(NUM_LR) : 0;
    localparam int LEAVES = 1 << LVLS;
    localparam int NODES  = 2 * LEAVES;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    // heap layout: node 1 is the root, children of n are 2n and 2n+1
    logic [PRIO_W-1:0]   node_prio [1:NODES-1];
    logic [LR_IDX_W-1:0] node_idx  [1:NODES-1];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_LR) begin : g_real
            logic grp_en;
            logic elig;
            assign grp_en = (lr_grp_i[i] == GRP1) ? ven1_i : ven0_i;
            assign elig   = (lr_state_i[i] == LR_PEND) && grp_en
                            && (lr_prio_i[i] != IDLE_PRIO);
            assign node_prio[LEAVES+i] = elig ? lr_prio_i[i] : IDLE_PRIO;
            assign node_idx[LEAVES+i]  = LR_IDX_W'(i);
        end else begin : g_pad
            assign node_prio[LEAVES+i] = IDLE_PRIO;
            assign node_idx[LEAVES+i]  = '0;
        end
    end

    for (genvar n = 1; n < LEAVES; n++) begin : g_node
        logic take_right;
        assign take_right   = node_prio[2*n+1] < node_prio[2*n];
        assign node_prio[n] = take_right ? node_prio[2*n+1] : node_prio[2*n];
        assign node_idx[n]  = take_right ? node_idx[2*n+1]  : node_idx[2*n];
    end

    assign best_prio_o = node_prio[1];
    assign best_idx_o  = node_idx[1];
    assign best_hit_o  = node_prio[1] != IDLE_PRIO;

endmodule

// File: rtl/vprio_cand_gate.sv
// Decides whether the cached message-signalled candidate overrides the
// best list-register entry.
module vprio_cand_gate #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic              cand_grp_i,
    input  logic              secure_i,
    input  logic              ven0_i,
    input  logic              ven1_i,
    input  logic [PRIO_W-1:0] lr_best_prio_i,
    output logic              cand_win_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import vprio_pkg::*;

    logic grp_en;
    logic beats;

    // an idle best entry carries all ones, so an idle candidate never beats it
    always_comb begin
        grp_en     = (cand_grp_i == GRP1) ? ven1_i : ven0_i;
        beats      = cand_prio_i < lr_best_prio_i;
        cand_win_o = !secure_i && grp_en && beats;
    end

endmodule

// File: rtl/vprio_sel.sv
module vprio_sel #(
    parameter int  NUM_LR = 16,
    parameter int  PRIO_W = 8,
    localparam int IDX_W  = $clog2(NUM_LR + 2)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LR-1:0][1:0]        lr_state_i,
    input  logic [NUM_LR-1:0][PRIO_W-1:0] lr_prio_i,
    input  logic [NUM_LR-1:0]             lr_grp_i,
    input  logic [PRIO_W-1:0]             cand_prio_i,
    input  logic                          cand_grp_i,
    input  logic                          secure_i,
    input  logic                          ven0_i,
    input  logic                          ven1_i,
    output logic [IDX_W-1:0]              sel_idx_o,
    output logic                          sel_none_o,
    output logic                          sel_vld_o
);
    timeunit 1ns;
    timeprecision 1ps;
    import vprio_pkg::*;

    localparam int LR_IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
    localparam logic [IDX_W-1:0]  CAND_CODE = IDX_W'(NUM_LR);
    localparam logic [IDX_W-1:0]  NONE_CODE = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             none;
        logic             vld;
        logic             seen;
    } sel_t;

    logic [PRIO_W-1:0]   lr_best_prio;
    logic [LR_IDX_W-1:0] lr_best_idx;
    logic                lr_hit;
    logic                cand_win;

    sel_t sel_d, sel_q;

    vprio_lr_scan #(
        .NUM_LR   (NUM_LR),
        .PRIO_W   (PRIO_W),
        .LR_IDX_W (LR_IDX_W)
    ) u_scan (
        .lr_state_i  (lr_state_i),
        .lr_prio_i   (lr_prio_i),
        .lr_grp_i    (lr_grp_i),
        .ven0_i      (ven0_i),
        .ven1_i      (ven1_i),
        .best_prio_o (lr_best_prio),
        .best_idx_o  (lr_best_idx),
        .best_hit_o  (lr_hit)
    );

    vprio_cand_gate #(
        .PRIO_W (PRIO_W)
    ) u_gate (
        .cand_prio_i    (cand_prio_i),
        .cand_grp_i     (cand_grp_i),
        .secure_i       (secure_i),
        .ven0_i         (ven0_i),
        .ven1_i         (ven1_i),
        .lr_best_prio_i (lr_best_prio),
        .cand_win_o     (cand_win)
    );

    always_comb begin
        sel_d = sel_q;
        if (cand_win) begin
            sel_d.idx = CAND_CODE;
        end else if (lr_hit) begin
            sel_d.idx = IDX_W'(lr_best_idx);
        end else begin
            sel_d.idx = NONE_CODE;
        end
        sel_d.none = !(cand_win || lr_hit);
        sel_d.vld  = !sel_q.seen || (sel_d.idx != sel_q.idx);
        sel_d.seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '{idx: NONE_CODE, none: 1'b1, vld: 1'b0, seen: 1'b0};
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_idx_o  = sel_q.idx;
    assign sel_none_o = sel_q.none;
    assign sel_vld_o  = sel_q.vld;

    // ---------------------------------------------------------------
    // Assertions, with shadow state sampled from the ports
    // ---------------------------------------------------------------
    logic                   chk_primed_q;
    logic [NUM_LR-1:0][1:0] chk_state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_primed_q <= 1'b0;
            chk_state_q  <= '0;
        end else begin
            chk_primed_q <= 1'b1;
            chk_state_q  <= lr_state_i;
        end
    end

    // R4: none flag agrees with the sentinel; index lies in a legal range
    a_r4_none_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sel_none_o == (sel_idx_o == NONE_CODE));

    a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx_o < CAND_CODE) || (sel_idx_o == CAND_CODE) || (sel_idx_o == NONE_CODE));

    // R2: a reported entry was pending-only in the sampled cycle
    a_r2_lr_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_primed_q && sel_idx_o < CAND_CODE)
        |-> chk_state_q[sel_idx_o[LR_IDX_W-1:0]] == LR_PEND);

    // R6: candidate never selected after a secure cycle
    a_r6_secure_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_primed_q && $past(secure_i)) |-> sel_idx_o != CAND_CODE);

    // R7: candidate selected only with its group enabled
    a_r7_cand_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_primed_q && sel_idx_o == CAND_CODE)
        |-> ($past(cand_grp_i) ? $past(ven1_i) : $past(ven0_i)));

    // R5: an idle candidate priority never wins
    a_r5_cand_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_primed_q && sel_idx_o == CAND_CODE) |-> $past(cand_prio_i) != IDLE_PRIO);

    // R9: every change of the registered index raises the strobe
    a_r9_vld_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_primed_q && sel_idx_o != $past(sel_idx_o)) |-> sel_vld_o);

endmodule

// File: tb/tb_vprio_sel.sv
module tb_vprio_sel;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NLR  = 16;
    localparam int PW   = 8;
    localparam int IW   = 5;
    localparam int CAND = 16;
    localparam int NONE = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NLR-1:0][1:0]    st;
    logic [NLR-1:0][PW-1:0] pr;
    logic [NLR-1:0]         gp;
    logic [PW-1:0]          cp;
    logic                   cg, sec, e0, e1;
    logic [IW-1:0]          sel_idx;
    logic                   sel_none, sel_vld;

    int n_chk = 0;
    int n_fail = 0;
    int last_exp = NONE;
    bit first = 1'b1;

    vprio_sel #(.NUM_LR(NLR), .PRIO_W(PW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lr_state_i(st), .lr_prio_i(pr), .lr_grp_i(gp),
        .cand_prio_i(cp), .cand_grp_i(cg), .secure_i(sec),
        .ven0_i(e0), .ven1_i(e1),
        .sel_idx_o(sel_idx), .sel_none_o(sel_none), .sel_vld_o(sel_vld)
    );

    // behavioural model of the selection rules
    function automatic int ref_sel();
        int best = -1;
        int bp = 255;
        for (int i = 0; i < NLR; i++) begin
            if (st[i] == 2'b01 && (gp[i] ? e1 : e0) && int'(pr[i]) < bp) begin
                best = i;
                bp = int'(pr[i]);
            end
        end
        if (!sec && (cg ? e1 : e0) && int'(cp) < bp) best = CAND;
        return (best < 0) ? NONE : best;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // inputs set at a falling edge are registered at the next rising edge
    task automatic tick(string tag);
        int e;
        e = ref_sel();
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(sel_idx), e);
        check(tag, int'(sel_none), (e == NONE) ? 1 : 0);
        check("R9", int'(sel_vld), (first || e != last_exp) ? 1 : 0);
        last_exp = e;
        first = 1'b0;
    endtask

    task automatic clear();
        st = '0; pr = '1; gp = '0;
        cp = '1; cg = 1'b0; sec = 1'b0; e0 = 1'b1; e1 = 1'b1;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear();
        repeat (3) @(negedge clk);
        check("R1", int'(sel_idx), NONE);
        check("R1", int'(sel_none), 1);
        check("R1", int'(sel_vld), 0);
        rst_n = 1'b1;

        tick("R4");                 // idle, first result strobes
        tick("R9");                 // held idle, no strobe

        st[5] = 2'b01; pr[5] = 8'h40; gp[5] = 1'b1;
        tick("R2");                 // expect 5
        e1 = 1'b0;
        tick("R2");                 // group disabled -> none
        e1 = 1'b1; st[5] = 2'b10;
        tick("R2");                 // active only -> none
        st[5] = 2'b11;
        tick("R2");                 // active and pending -> none
        st[5] = 2'b01; pr[5] = 8'hFF;
        tick("R4");                 // idle priority -> none

        clear();
        st[3] = 2'b01; pr[3] = 8'h20;
        st[9] = 2'b01; pr[9] = 8'h20;
        tick("R3");                 // expect 3
        clear();
        st[15] = 2'b01; pr[15] = 8'h10;
        st[0]  = 2'b01; pr[0]  = 8'h10;
        tick("R3");                 // expect 0
        st[7] = 2'b01; pr[7] = 8'h08;
        tick("R2");                 // expect 7

        clear();
        st[2] = 2'b01; pr[2] = 8'h20; gp[2] = 1'b1;
        cp = 8'h10; cg = 1'b1;
        tick("R5");                 // candidate wins -> 16
        cp = 8'h20;
        tick("R5");                 // equal -> entry 2
        cp = 8'h30;
        tick("R5");                 // worse -> entry 2
        cp = 8'h10; sec = 1'b1;
        tick("R6");                 // secure -> entry 2
        sec = 1'b0; cg = 1'b0; e0 = 1'b0;
        tick("R7");                 // group 0 disabled -> entry 2
        e0 = 1'b1;
        tick("R7");                 // group 0 enabled -> 16

        clear();
        cp = 8'h80;
        tick("R5");                 // no entry, candidate -> 16
        cp = 8'hFF;
        tick("R5");                 // idle candidate -> none
        sec = 1'b1; cp = 8'h00;
        tick("R6");                 // secure -> none

        clear();
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 3) != 0) begin
                for (int i = 0; i < NLR; i++) begin
                    st[i] = 2'($urandom_range(0, 3));
                    pr[i] = ($urandom_range(0, 7) == 0) ? 8'hFF : 8'($urandom_range(0, 7) * 32);
                    gp[i] = 1'($urandom_range(0, 1));
                end
                cp  = ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 7) * 32);
                cg  = 1'($urandom_range(0, 1));
                sec = ($urandom_range(0, 3) == 0);
                e0  = ($urandom_range(0, 4) != 0);
                e1  = ($urandom_range(0, 4) != 0);
            end
            tick("R8");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule